// File: doc/BRIEF.md
# Configurable Bidirectional I/O Port

An eight-pin I/O port that sits between a processor register bus and a block of programmable logic. A per-pin control bit selects the pin's mode. In processor mode, the output value comes from a data-out register. In logic mode, it comes from the matching macrocell output of the logic array. The pad driver is enabled when either the array's enable term for that pin or the pin's direction bit is set. When the array defines no enable term for a pin, it ties that term low, and the direction bit alone controls the driver.

Every pin also has an input cell. The cell can pass the pad value straight through, act as a transparent latch, or act as an edge-sampled register. The latch and register modes are gated by a capture strobe that the array supplies, and the strobe is sampled on the port clock. The cell outputs feed the array input bus. The processor can also read the cell outputs, together with the raw pad levels and every writable register, over the register bus.

Top module: `pio_port`

## Requirements
- R1: A synchronous reset clears the data-out, direction, control and cell-mode registers and every cell's storage, so every pin comes up as a processor-mode input. With all array enable terms low, every driver is disabled.
- R2: A write takes effect on the clock edge where `bus_we` is high. The register addresses are: data-out at 1, direction at 2, control at 3, cell mode for pins 0..3 at 5, and cell mode for pins 4..7 at 6. Reading any of these addresses returns the last value written to it.
- R3: Each bit of `pad_oe` equals the OR of that pin's `arr_oe` bit and its direction bit.
- R4: When a pin's control bit is 0, its `pad_out` bit equals its data-out register bit.
- R5: When a pin's control bit is 1, its `pad_out` bit equals the same-numbered `mc_out` bit, and the data-out bit has no effect on it.
- R6: A read at address 0 returns the raw `pad_in` value, and a read at address 7 returns 0. Writes to addresses 0, 4 and 7 change no register.
- R7: The cell-mode field of pin k sits at bits [2k+1:2k] of its mode register (pin k-4 position for pins 4..7). Field code 00 selects direct mode, in which `cell_q[k]` equals `pad_in[k]`.
- R8: Code 01 selects latch mode. While `arr_clk` is high, `cell_q[k]` follows `pad_in[k]`. While `arr_clk` is low, `cell_q[k]` holds the `pad_in[k]` value sampled at the last clock edge where `arr_clk` was high.
- R9: Code 10 selects register mode, in which `cell_q[k]` equals `pad_in[k]` as sampled at the last clock edge where `arr_clk` was high.
- R10: A read at address 4 returns `cell_q`. Code 11 behaves as direct mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| arr_oe | input | 8 | Array output-enable terms, one per pin |
| arr_clk | input | 1 | Array capture strobe for the input cells |
| mc_out | input | 8 | Macrocell outputs, bit n drives pin n in logic mode |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad driver enables |
| cell_q | output | 8 | Input cell outputs to the array input bus |

## Verification
The embedded properties check four things on every cycle: that a register write lands on the next edge, that writes to read-only addresses leave the configuration untouched, that a newly set direction bit turns its driver on, and that each cell either captures or holds according to the strobe. They also check that a transparent latch follows its pad. Some behaviour only the bench scenarios can show: the per-pin choice between register and macrocell sources, and the OR of the enable term with the direction bit under mixed stimulus. The same applies to field placement within the two mode registers and to the handling of mode code 11. The bench shows these against a reference model, using random bus traffic and random pad and strobe activity.

// File: rtl/pio_pkg.sv
package pio_pkg;

    localparam int PIN_W  = 8;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_PIN  = 3'd0;
    localparam logic [ADDR_W-1:0] A_DOUT = 3'd1;
    localparam logic [ADDR_W-1:0] A_DIR  = 3'd2;
    localparam logic [ADDR_W-1:0] A_CTL  = 3'd3;
    localparam logic [ADDR_W-1:0] A_CELL = 3'd4;
    localparam logic [ADDR_W-1:0] A_MLO  = 3'd5;
    localparam logic [ADDR_W-1:0] A_MHI  = 3'd6;

    typedef enum logic [1:0] {
        CM_DIRECT = 2'b00,
        CM_LATCH  = 2'b01,
        CM_REG    = 2'b10,
        CM_SPARE  = 2'b11
    } cell_mode_e;

    typedef struct packed {
        logic [2*PIN_W-1:0] cmode;
        logic [PIN_W-1:0]   ctl;
        logic [PIN_W-1:0]   dir;
        logic [PIN_W-1:0]   dout;
    } port_cfg_t;

    function automatic cell_mode_e pin_mode(input logic [2*PIN_W-1:0] f, input int n);
        return cell_mode_e'(f[2*n +: 2]);
    endfunction

endpackage

// File: rtl/pio_regs.sv
module pio_regs
    import pio_pkg::*;
#(
    parameter int W  = PIN_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    input  logic [W-1:0]  pin_raw,
    input  logic [W-1:0]  cell_q,
    output port_cfg_t     cfg,
    output logic [W-1:0]  rdata
);

    port_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (we) begin
            unique case (addr)
                A_DOUT:  cfg_q.dout          <= wdata;
                A_DIR:   cfg_q.dir           <= wdata;
                A_CTL:   cfg_q.ctl           <= wdata;
                A_MLO:   cfg_q.cmode[W-1:0]   <= wdata;
                A_MHI:   cfg_q.cmode[2*W-1:W] <= wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (addr)
            A_PIN:   rdata = pin_raw;
            A_DOUT:  rdata = cfg_q.dout;
            A_DIR:   rdata = cfg_q.dir;
            A_CTL:   rdata = cfg_q.ctl;
            A_CELL:  rdata = cell_q;
            A_MLO:   rdata = cfg_q.cmode[W-1:0];
            A_MHI:   rdata = cfg_q.cmode[2*W-1:W];
            default: rdata = '0;
        endcase
    end

    assign cfg = cfg_q;

    // R2
    dout_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (we && addr == A_DOUT) |=> (cfg_q.dout == $past(wdata)));

    // R6
    ro_write_chk: assert property (@(posedge clk) disable iff (rst)
        (we && (addr == A_PIN || addr == A_CELL || addr == 3'd7)) |=> $stable(cfg_q));

endmodule

// File: rtl/pio_in_cell.sv
module pio_in_cell
    import pio_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  cell_mode_e mode,
    input  logic       cap_en,
    input  logic       pin,
    output logic       q
);

    logic held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= 1'b0;
        end else if (cap_en) begin
            held_q <= pin;
        end
    end

    always_comb begin
        unique case (mode)
            CM_LATCH: q = cap_en ? pin : held_q;
            CM_REG:   q = held_q;
            default:  q = pin;
        endcase
    end

    // R9
    capture_chk: assert property (@(posedge clk) disable iff (rst)
        cap_en |=> (held_q == $past(pin)));

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !cap_en |=> $stable(held_q));

    // R8
    latch_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == CM_LATCH && cap_en) |-> (q == pin));

endmodule

// File: rtl/pio_pin_drv.sv
module pio_pin_drv #(
    parameter int W = pio_pkg::PIN_W
) (
    input  logic [W-1:0] dout,
    input  logic [W-1:0] dir,
    input  logic [W-1:0] ctl,
    input  logic [W-1:0] arr_oe,
    input  logic [W-1:0] mc_out,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe
);

    for (genvar i = 0; i < W; i++) begin : g_pin
        assign pad_out[i] = ctl[i] ? mc_out[i] : dout[i];
        assign pad_oe[i]  = arr_oe[i] | dir[i];
    end

endmodule

// File: rtl/pio_port.sv
module pio_port
    import pio_pkg::*;
#(
    parameter int W  = PIN_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_we,
    input  logic [W-1:0]  bus_wdata,
    output logic [W-1:0]  bus_rdata,
    input  logic [W-1:0]  arr_oe,
    input  logic          arr_clk,
    input  logic [W-1:0]  mc_out,
    input  logic [W-1:0]  pad_in,
    output logic [W-1:0]  pad_out,
    output logic [W-1:0]  pad_oe,
    output logic [W-1:0]  cell_q
);

    port_cfg_t cfg;

    pio_regs #(.W(W), .AW(AW)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (bus_we),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .pin_raw (pad_in),
        .cell_q  (cell_q),
        .cfg     (cfg),
        .rdata   (bus_rdata)
    );

    for (genvar k = 0; k < W; k++) begin : g_cell
        pio_in_cell u_cell (
            .clk    (clk),
            .rst    (rst),
            .mode   (pin_mode(cfg.cmode, k)),
            .cap_en (arr_clk),
            .pin    (pad_in[k]),
            .q      (cell_q[k])
        );
    end

    pio_pin_drv #(.W(W)) u_drv (
        .dout    (cfg.dout),
        .dir     (cfg.dir),
        .ctl     (cfg.ctl),
        .arr_oe  (arr_oe),
        .mc_out  (mc_out),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );

    // R3
    dir_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == A_DIR) |=> ((pad_oe & $past(bus_wdata)) == $past(bus_wdata)));

endmodule

// File: tb/test_pio_port.sv
`timescale 1ns/1ps
module test_pio_port;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bus_addr = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] arr_oe = '0;
    logic       arr_clk = 1'b0;
    logic [7:0] mc_out = '0;
    logic [7:0] pad_in = '0;
    logic [7:0] pad_out, pad_oe, cell_q;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [7:0]  m_dout, m_dir, m_ctl, m_st;
    logic [15:0] m_mode;

    always #2.5 clk = ~clk;

    pio_port i_pio_port (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .arr_oe(arr_oe),
        .arr_clk(arr_clk), .mc_out(mc_out), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .cell_q(cell_q)
    );

    function automatic logic exp_cell(int k);
        logic [1:0] m = m_mode[2*k +: 2];
        case (m)
            2'b01:   return arr_clk ? pad_in[k] : m_st[k];
            2'b10:   return m_st[k];
            default: return pad_in[k];
        endcase
    endfunction

    function automatic logic [7:0] exp_cells();
        logic [7:0] v;
        for (int k = 0; k < 8; k++) v[k] = exp_cell(k);
        return v;
    endfunction

    function automatic logic [7:0] exp_rdata(logic [2:0] a);
        case (a)
            3'd0: return pad_in;
            3'd1: return m_dout;
            3'd2: return m_dir;
            3'd3: return m_ctl;
            3'd4: return exp_cells();
            3'd5: return m_mode[7:0];
            3'd6: return m_mode[15:8];
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_outputs();
        check("R3 pad_oe", pad_oe, arr_oe | m_dir);
        for (int k = 0; k < 8; k++) begin
            if (m_ctl[k]) check("R5 pad_out", {7'd0, pad_out[k]}, {7'd0, mc_out[k]});
            else          check("R4 pad_out", {7'd0, pad_out[k]}, {7'd0, m_dout[k]});
            case (m_mode[2*k +: 2])
                2'b00:   check("R7 cell_q", {7'd0, cell_q[k]}, {7'd0, exp_cell(k)});
                2'b01:   check("R8 cell_q", {7'd0, cell_q[k]}, {7'd0, exp_cell(k)});
                2'b10:   check("R9 cell_q", {7'd0, cell_q[k]}, {7'd0, exp_cell(k)});
                default: check("R10 cell_q", {7'd0, cell_q[k]}, {7'd0, exp_cell(k)});
            endcase
        end
        case (bus_addr)
            3'd0, 3'd7: check("R6 rdata", bus_rdata, exp_rdata(bus_addr));
            3'd4:       check("R10 rdata", bus_rdata, exp_rdata(bus_addr));
            default:    check("R2 rdata", bus_rdata, exp_rdata(bus_addr));
        endcase
    endtask

    task automatic model_edge();
        if (rst) begin
            m_dout = '0; m_dir = '0; m_ctl = '0; m_mode = '0; m_st = '0;
        end else begin
            if (arr_clk) m_st = pad_in;
            if (bus_we) begin
                case (bus_addr)
                    3'd1: m_dout = bus_wdata;
                    3'd2: m_dir = bus_wdata;
                    3'd3: m_ctl = bus_wdata;
                    3'd5: m_mode[7:0] = bus_wdata;
                    3'd6: m_mode[15:8] = bus_wdata;
                    default: ;
                endcase
            end
        end
    endtask

    task automatic step(logic [2:0] a, logic we, logic [7:0] wd,
                        logic [7:0] pin, logic [7:0] oe, logic ac, logic [7:0] mc);
        @(negedge clk);
        bus_addr = a; bus_we = we; bus_wdata = wd;
        pad_in = pin; arr_oe = oe; arr_clk = ac; mc_out = mc;
        #1;
        check_outputs();
        @(posedge clk);
        model_edge();
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        m_dout = '0; m_dir = '0; m_ctl = '0; m_mode = '0; m_st = '0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        bus_we = 1'b0; arr_oe = '0; arr_clk = 1'b0; pad_in = 8'hA5;
        #1;
        // R1: reset state
        check("R1 pad_oe", pad_oe, 8'h00);
        check("R1 cell_q", cell_q, 8'hA5);
        for (int a = 1; a < 7; a++) begin
            bus_addr = 3'(a);
            #0.1;
            if (a != 4) check("R1 rdata", bus_rdata, 8'h00);
        end

        // directed: direction only (R3), then enable term alone
        step(3'd2, 1, 8'h0F, 8'h00, 8'h00, 0, 8'h00);
        step(3'd2, 0, 8'h00, 8'h00, 8'h30, 0, 8'h00);
        // data-out in processor mode (R4), then logic mode (R5)
        step(3'd1, 1, 8'h5A, 8'h00, 8'h00, 0, 8'hFF);
        step(3'd3, 1, 8'hF0, 8'h00, 8'h00, 0, 8'h0F);
        step(3'd1, 0, 8'h00, 8'h00, 8'h00, 0, 8'hC3);
        // read-only writes ignored (R6)
        step(3'd0, 1, 8'hFF, 8'h11, 8'h00, 0, 8'h00);
        step(3'd4, 1, 8'hFF, 8'h22, 8'h00, 0, 8'h00);
        step(3'd7, 1, 8'hFF, 8'h33, 8'h00, 0, 8'h00);
        step(3'd1, 0, 8'h00, 8'h44, 8'h00, 0, 8'h00);
        // cell modes: pins0..3 = direct,latch,reg,spare; pins4..7 = reg,latch,direct,reg
        step(3'd5, 1, 8'b11_10_01_00, 8'h00, 8'h00, 0, 8'h00);
        step(3'd6, 1, 8'b10_00_01_10, 8'h00, 8'h00, 0, 8'h00);
        // latch/register capture then hold (R8, R9, R10)
        step(3'd4, 0, 8'h00, 8'hFF, 8'h00, 1, 8'h00);
        step(3'd4, 0, 8'h00, 8'h00, 8'h00, 0, 8'h00);
        step(3'd4, 0, 8'h00, 8'h55, 8'h00, 0, 8'h00);
        step(3'd4, 0, 8'h00, 8'hAA, 8'h00, 1, 8'h00);
        step(3'd4, 0, 8'h00, 8'h0F, 8'h00, 0, 8'h00);

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [2:0] a  = 3'($urandom_range(0, 7));
            logic       we = ($urandom_range(0, 1) == 1);
            logic       ac = ($urandom_range(0, 9) < 3);
            step(a, we, 8'($urandom), 8'($urandom), 8'($urandom) & 8'($urandom),
                 ac, 8'($urandom));
        end

        // reset mid-run then verify cleared state (R1)
        @(negedge clk);
        rst = 1'b1; bus_we = 1'b0;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        rst = 1'b0; arr_oe = '0; arr_clk = 1'b0;
        #1;
        check("R1 pad_oe after reset", pad_oe, 8'h00);
        check("R1 cell_q after reset", cell_q, pad_in);
        step(3'd3, 0, 8'h00, 8'h3C, 8'h00, 0, 8'hFF);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule